// File: doc/BRIEF.md
# Service Status Hub with Masked Interrupt

This block gives a host one 16-bit summary register to poll, so that it can see at a glance which major sub-block of a chip needs attention. Two kinds of bit share the register. Latched event bits capture one-shot occurrences and hold them until the host reads the register. A real-time bit follows a qualified summary level that a sub-block presents.

A built-in generator marks one-second boundaries by counting enable pulses from a reference timebase. Each such boundary is one of the latched events. A saturation level from the error counters is edge-qualified, so that a counter that stays full is reported only once. A separate mask register selects which status bits can drive the active-high level interrupt.

The host uses a simple synchronous register port. A read strobe loads the addressed register into a registered read-data output, and the value appears one clock later. A write strobe updates the mask register.

Top module: `svc_status_hub`

## Requirements
- R1: After a synchronous reset the status register, the mask register, `host_rdata` and `irq` are all zero.
- R2: Status bit 0 is set on the clock after every SEC_COUNT-th cycle in which `ref_tick` is high. Cycles with `ref_tick` low do not advance the one-second count.
- R3: A read strobe at address 08h returns the status register on `host_rdata` one clock later. The same read clears the latched bits 0 and 1.
- R4: Status bit 1 is set on the clock after a rising edge of `sat_lvl`. If `sat_lvl` stays high, a clearing read leaves the bit clear and it is not set again.
- R5: If a latched event occurs in the same cycle as a clearing read, the bit stays set. The read still returns the value the register held before that event.
- R6: Status bit 2 equals, one clock later, `chk_irq_en` AND (`chk_sync_chg` OR `chk_bit_err` OR `chk_cnt_ovf`). A read does not clear it.
- R7: The mask register at address 0Ah keeps bits [2:0] of a write. Its other bits always read as zero.
- R8: `irq` is high exactly when some status bit and its mask bit are both one, and it changes in the same clock as the status and mask registers.
- R9: A write to 08h does not change the status register. Status bits [15:3] read as zero, and a read of any address other than 08h or 0Ah returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One pulse per reference timebase period |
| sat_lvl | input | 1 | High while any error counter is saturated |
| chk_sync_chg | input | 1 | Pattern checker reports a sync gain or loss |
| chk_bit_err | input | 1 | Pattern checker reports a bit error |
| chk_cnt_ovf | input | 1 | Pattern checker bit or error counter overflow |
| chk_irq_en | input | 1 | Pattern checker's own interrupt enable |
| host_addr | input | ADDR_W | Register address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
Two functions can land in the same cycle: a clearing read of 08h and a new latched event, which is either a one-second pulse or a saturation edge. The bench provokes the pulse case by issuing back-to-back reads of 08h while the reference count runs through a boundary. It provokes the saturation case by raising `sat_lvl` in the very cycle of a read. The behavioural model judges both cases: the returned word must lack the new event, and the bit must still be set at the next read, with `irq` staying high if the bit is masked in.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h08;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h0A;
  localparam int BIT_SEC = 0;
  localparam int BIT_SAT = 1;
  localparam int BIT_CHK = 2;
  localparam int NUM_LATCHED = 2;
  localparam logic [DATA_W-1:0] IMPL_BITS = 16'h0007;
endpackage

// File: rtl/sec_pulse_gen.sv
module sec_pulse_gen #(
  parameter int SEC_COUNT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  output logic sec_pulse
);
  localparam int CW = (SEC_COUNT > 1) ? $clog2(SEC_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = ref_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= wrap;
      if (ref_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: count only advances on reference ticks
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(cnt_q));
  // R2: boundary pulse lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && SEC_COUNT > 1) |=> !sec_pulse);
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_lvl,
  input  logic         clr,
  output logic [N-1:0] latch_q,
  output logic [N-1:0] latch_d
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i]    = evt_lvl[i] & ~prev_q[i];
    assign latch_d[i] = rise[i] | (latch_q[i] & ~clr);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i]  <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q[i]  <= evt_lvl[i];
        latch_q[i] <= latch_d[i];
      end
    end

    // R5: an event never loses to a clearing read
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
      (evt_lvl[i] && !prev_q[i]) |=> latch_q[i]);
    // R3: a read with no new event clears the bit
    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (rst)
      (clr && !(evt_lvl[i] && !prev_q[i])) |=> !latch_q[i]);
    // R4: a level held high cannot set the bit again
    a_r4_level_no_reset: assert property (@(posedge clk) disable iff (rst)
      (evt_lvl[i] && prev_q[i] && !latch_q[i]) |=> !latch_q[i]);
  end
endmodule

// File: rtl/svc_status_hub.sv
module svc_status_hub
  import svc_status_pkg::*;
#(
  parameter int SEC_COUNT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              sat_lvl,
  input  logic              chk_sync_chg,
  input  logic              chk_bit_err,
  input  logic              chk_cnt_ovf,
  input  logic              chk_irq_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  logic                   sec_pulse;
  logic                   rd_stat;
  logic                   wr_mask;
  logic [NUM_LATCHED-1:0] evt_lvl;
  logic [NUM_LATCHED-1:0] lat_q;
  logic [NUM_LATCHED-1:0] lat_d;
  logic                   rt_q;
  logic                   rt_d;
  logic [DATA_W-1:0]      mask_q;
  logic [DATA_W-1:0]      mask_d;
  logic [DATA_W-1:0]      stat_q;
  logic [DATA_W-1:0]      stat_d;

  assign rd_stat = host_rd && (host_addr == STAT_ADDR);
  assign wr_mask = host_wr && (host_addr == MASK_ADDR);

  sec_pulse_gen #(.SEC_COUNT(SEC_COUNT)) u_sec (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .sec_pulse (sec_pulse)
  );

  assign evt_lvl[BIT_SEC] = sec_pulse;
  assign evt_lvl[BIT_SAT] = sat_lvl;

  evt_latch_bank #(.N(NUM_LATCHED)) u_lat (
    .clk     (clk),
    .rst     (rst),
    .evt_lvl (evt_lvl),
    .clr     (rd_stat),
    .latch_q (lat_q),
    .latch_d (lat_d)
  );

  assign rt_d   = chk_irq_en & (chk_sync_chg | chk_bit_err | chk_cnt_ovf);
  assign mask_d = wr_mask ? (host_wdata & IMPL_BITS) : mask_q;

  always_comb begin
    stat_q = '0;
    stat_d = '0;
    stat_q[NUM_LATCHED-1:0] = lat_q;
    stat_d[NUM_LATCHED-1:0] = lat_d;
    stat_q[BIT_CHK] = rt_q;
    stat_d[BIT_CHK] = rt_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q       <= 1'b0;
      mask_q     <= '0;
      host_rdata <= '0;
      irq        <= 1'b0;
    end else begin
      rt_q   <= rt_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & mask_d);
      if (host_rd) begin
        if (host_addr == STAT_ADDR)      host_rdata <= stat_q;
        else if (host_addr == MASK_ADDR) host_rdata <= mask_q;
        else                             host_rdata <= '0;
      end
    end
  end

  // R8: interrupt agrees with masked status held in registers
  a_r8_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & mask_q));
  // R7: unimplemented mask bits stay zero
  a_r7_mask_bits: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~IMPL_BITS) == '0);
  // R9: status reads never expose upper bits
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> host_rdata[DATA_W-1:3] == '0);
  // R6: real-time bit follows the qualified summary
  a_r6_realtime: assert property (@(posedge clk) disable iff (rst)
    (chk_irq_en && (chk_sync_chg || chk_bit_err || chk_cnt_ovf)) |=> rt_q);
endmodule

// File: tb/svc_status_hub_test.sv
module svc_status_hub_test;
  localparam int SEC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0, sat_lvl = 1'b0;
  logic        c_sync = 1'b0, c_err = 1'b0, c_ovf = 1'b0, c_ie = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  int   m_cnt = 0;
  bit   m_pulse = 0, m_sat_prev = 0, m_sec_prev = 0;
  bit   m_l0 = 0, m_l1 = 0, m_rt = 0, m_irq = 0;
  bit [15:0] m_mask = 0, m_rdata = 0;

  svc_status_hub #(.SEC_COUNT(SEC)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .sat_lvl(sat_lvl),
    .chk_sync_chg(c_sync), .chk_bit_err(c_err), .chk_cnt_ovf(c_ovf),
    .chk_irq_en(c_ie), .host_addr(addr), .host_rd(rd), .host_wr(wr),
    .host_wdata(wdata), .host_rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    bit clr, sec_ev, sat_ev, l0n, l1n, rtn, pn;
    bit [15:0] mn, stat;
    if (rst) begin
      m_cnt = 0; m_pulse = 0; m_sat_prev = 0; m_sec_prev = 0;
      m_l0 = 0; m_l1 = 0; m_rt = 0; m_irq = 0; m_mask = 0; m_rdata = 0;
    end else begin
      stat   = {13'd0, m_rt, m_l1, m_l0};
      clr    = rd && addr == 8'h08;
      sec_ev = m_pulse && !m_sec_prev;
      sat_ev = sat_lvl && !m_sat_prev;
      l0n    = sec_ev || (m_l0 && !clr);
      l1n    = sat_ev || (m_l1 && !clr);
      rtn    = c_ie && (c_sync || c_err || c_ovf);
      mn     = (wr && addr == 8'h0A) ? (wdata & 16'h0007) : m_mask;
      if (rd) m_rdata = (addr == 8'h08) ? stat : (addr == 8'h0A) ? m_mask : 16'h0;
      pn = ref_tick && (m_cnt == SEC - 1);
      if (ref_tick) m_cnt = pn ? 0 : m_cnt + 1;
      m_sec_prev = m_pulse; m_pulse = pn; m_sat_prev = sat_lvl;
      m_l0 = l0n; m_l1 = l1n; m_rt = rtn; m_mask = mn;
      m_irq = |({13'd0, rtn, l1n, l0n} & mn);
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rdata !== m_rdata || irq !== m_irq) begin
        errors++;
        $display("FAIL %s rdata=%h irq=%b expected rdata=%h irq=%b", cur_req, rdata, irq, m_rdata, m_irq);
      end
    end
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_read(logic [7:0] a);
    addr = a; rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic host_write(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; step(); wr = 1'b0;
  endtask

  initial begin
    step(3);
    expect_val("R1 rdata at reset", rdata, 16'h0);
    expect_val("R1 irq at reset", {15'd0, irq}, 16'h0);
    rst = 1'b0; step();
    host_read(8'h0A); step();
    expect_val("R1 mask at reset", rdata, 16'h0);

    cur_req = "R7";
    host_write(8'h0A, 16'hFFFF); host_read(8'h0A); step();
    expect_val("R7 mask readback", rdata, 16'h0007);
    host_write(8'h0A, 16'h0002); host_read(8'h0A); step();
    expect_val("R7 mask partial", rdata, 16'h0002);

    cur_req = "R4";
    sat_lvl = 1'b1; step(2);
    expect_val("R4 irq on saturation", {15'd0, irq}, 16'h1);
    host_read(8'h08); step();
    expect_val("R4 bit1 seen", rdata, 16'h0002);
    step(3); host_read(8'h08); step();
    expect_val("R4 no re-set while held", rdata, 16'h0000);
    expect_val("R8 irq cleared after read", {15'd0, irq}, 16'h0);
    sat_lvl = 1'b0; step(2);

    cur_req = "R6";
    host_write(8'h0A, 16'h0004);
    c_err = 1'b1; step(2);
    expect_val("R6 gated by enable", {15'd0, irq}, 16'h0);
    c_ie = 1'b1; step(2);
    expect_val("R6 irq from real-time bit", {15'd0, irq}, 16'h1);
    host_read(8'h08); step(); host_read(8'h08); step();
    expect_val("R6 not cleared by read", rdata, 16'h0004);
    c_err = 1'b0; c_sync = 1'b1; step(2); c_sync = 1'b0; c_ovf = 1'b1; step(2);
    c_ovf = 1'b0; step(2);
    expect_val("R6 follows summary low", {15'd0, irq}, 16'h0);
    c_ie = 1'b0;

    cur_req = "R9";
    host_write(8'h08, 16'hFFFF); host_read(8'h08); step();
    expect_val("R9 write to status ignored", rdata, 16'h0000);
    host_read(8'h33); step();
    expect_val("R9 unmapped address", rdata, 16'h0000);

    cur_req = "R2";
    host_write(8'h0A, 16'h0001);
    for (int k = 0; k < 3 * SEC + 5; k++) begin
      ref_tick = k[0]; step();
    end
    ref_tick = 1'b0; step(2);
    expect_val("R2 irq on second boundary", {15'd0, irq}, 16'h1);
    host_read(8'h08); step();
    expect_val("R2 bit0 latched", rdata, 16'h0001);

    cur_req = "R5";
    ref_tick = 1'b1;
    for (int k = 0; k < 2 * SEC + 3; k++) begin
      addr = 8'h08; rd = 1'b1; step();
    end
    rd = 1'b0; ref_tick = 1'b0;
    host_write(8'h0A, 16'h0002); host_read(8'h08); step();
    addr = 8'h08; rd = 1'b1; sat_lvl = 1'b1; step(); rd = 1'b0; step();
    expect_val("R5 read returns pre-event value", rdata, 16'h0000);
    expect_val("R5 irq kept by event", {15'd0, irq}, 16'h1);
    host_read(8'h08); step();
    expect_val("R5 bit1 survived read", rdata, 16'h0002);
    sat_lvl = 1'b0;

    cur_req = "R3";
    host_read(8'h08); step();
    expect_val("R3 cleared after read", rdata, 16'h0000);

    cur_req = "R1";
    rst = 1'b1; step(2); rst = 1'b0; step();
    expect_val("R1 rdata after second reset", rdata, 16'h0);
    step(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule